// File: doc/BRIEF.md
# Single-Level Interrupt Recognizer

This block decides when an external interrupt is accepted by a small processor core and issues the vectoring actions in that same cycle. It samples a dedicated interrupt pin on every instruction-cycle tick. It qualifies a falling pulse only after the pin has been seen high and then low on two consecutive ticks. A qualified edge is latched as pending, but only while the interrupt-enable bit is set. The pending request waits until the core signals that the current instruction has finished.

When the request is taken, the block asserts a program-counter load with the fixed vector 0x0FF. It also asserts a push of the return address, which is the incoming PC plus one, onto its own three-entry stack. The enable bit clears in the next cycle, so no further interrupt is accepted until software sets it again. The stack has no overflow check: a push into a full stack discards the oldest entry. Software controls the enable bit through separate set and clear strobes, and the new value is visible one cycle after the strobe.

Top module: `irq_recognizer`

## Requirements
- R1: After reset, int_en and int_pending are 0, every stack entry is 0, and pc_load and push_valid are 0.
- R2: The pin is sampled only in cycles where cyc_tick is 1. A qualified edge occurs in the tick cycle that shows the second consecutive low sample, and only if the sample just before those two lows was high. A low pulse lasting a single tick never qualifies.
- R3: A qualified edge sets int_pending in the next cycle only if int_en is 1. An edge seen while int_en is 0 is not remembered, and int_pending stays 0 after int_en is later set.
- R4: Once set, int_pending stays 1 until instr_done is 1, unless software clears the enable. The interrupt is taken, with pc_load=1, exactly in a cycle where int_pending and instr_done are both 1.
- R5: In the cycle the interrupt is taken, pc_load is 1 and pc_vector is 10'h0FF.
- R6: In the cycle the interrupt is taken, push_valid is 1 and push_addr equals (pc_in + 1) mod 1024.
- R7: A push moves each stack entry one place deeper and writes push_addr into entry 0, which is stack_entries[9:0]. Entry 2, stack_entries[29:20], is lost on a push.
- R8: In the cycle after the interrupt is taken, int_en and int_pending are 0. This holds even if en_set was 1 in the cycle of the take.
- R9: en_set makes int_en 1 from the next cycle. en_clr makes int_en 0 and drops int_pending from the next cycle. If both strobes are 1 together, the clear wins.
- R10: A low level held for many ticks produces only one qualified edge. The pin must be sampled high again before another edge can qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-cycle strobe per instruction cycle; the pin is sampled here |
| int_pin | input | 1 | External interrupt input (active falling pulse) |
| instr_done | input | 1 | Current instruction completes in this cycle |
| pc_in | input | 10 | Program counter of the completing instruction |
| en_set | input | 1 | Software strobe setting the enable bit |
| en_clr | input | 1 | Software strobe clearing the enable bit |
| int_en | output | 1 | Current interrupt-enable bit |
| int_pending | output | 1 | Qualified edge held awaiting instruction completion |
| pc_load | output | 1 | Load program counter with pc_vector (interrupt taken) |
| pc_vector | output | 10 | Fixed vector address 0x0FF |
| push_valid | output | 1 | Push push_addr onto the return stack |
| push_addr | output | 10 | Return address, pc_in + 1 |
| stack_entries | output | 30 | Stack contents, entry 0 (newest) in bits 9:0 |

## Verification
The pin is driven with single-tick low glitches, which must be rejected, and with two-tick and much longer low pulses, which must produce one pending request each. Pulses are also sent while the enable bit is clear, which separates "edge forgotten" from "edge queued until enabled". The instruction-done strobe is withheld for many cycles and then given, which shows that the request is held rather than taken early. Pushes with a PC of 0x3FF and four pushes in a row expose wrap-around of the return address and loss of the oldest stack entry. Set and clear strobes are also issued together and in the cycle of a take, to confirm that the clear wins.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DEF_PC_W        = 10;
  localparam int DEF_STACK_DEPTH = 3;
  localparam int DEF_LOW_TICKS   = 2;
  localparam int DEF_VECTOR      = 'h0FF;
endpackage

// File: rtl/irq_pulse_qual.sv
// Samples the pin on each instruction tick and flags a falling pulse
// that has stayed low for LOW_TICKS consecutive samples after a high one.
module irq_pulse_qual #(
  parameter int LOW_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic qual
);
  localparam logic [LOW_TICKS-1:0] ARMED = {1'b1, {(LOW_TICKS-1){1'b0}}};

  logic [LOW_TICKS-1:0] hist;

  // Reset history to all-low so the pin must be seen high before an edge counts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist <= '0;
    else if (tick) hist <= {hist[LOW_TICKS-2:0], pin};
  end

  assign qual = tick & ~pin & (hist == ARMED);
endmodule

// File: rtl/irq_take_ctrl.sv
// Enable bit and pending latch; decides the take cycle.
module irq_take_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  input  logic instr_done,
  input  logic en_set,
  input  logic en_clr,
  output logic en_q,
  output logic pend_q,
  output logic take
);
  logic en_d;
  logic pend_d;

  assign take = pend_q & en_q & instr_done;

  always_comb begin
    en_d = en_q;
    if (en_set)        en_d = 1'b1;
    if (en_clr | take) en_d = 1'b0;
    pend_d = en_q & ~take & ~en_clr & (pend_q | qual);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irq_ret_stack.sv
// Shift-down return stack; the deepest entry falls off on every push.
module irq_ret_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [W-1:0]       din,
  output logic [DEPTH*W-1:0] entries
);
  logic [W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[i] <= '0;
      else if (push) begin
        if (i == 0) slot[i] <= din;
        else        slot[i] <= slot[(i > 0) ? i-1 : 0];
      end
    end
    assign entries[i*W +: W] = slot[i];
  end
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
  import irq_pkg::*;
#(
  parameter int PC_W        = DEF_PC_W,
  parameter int STACK_DEPTH = DEF_STACK_DEPTH,
  parameter int LOW_TICKS   = DEF_LOW_TICKS,
  parameter int VECTOR      = DEF_VECTOR
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cyc_tick,
  input  logic                      int_pin,
  input  logic                      instr_done,
  input  logic [PC_W-1:0]           pc_in,
  input  logic                      en_set,
  input  logic                      en_clr,
  output logic                      int_en,
  output logic                      int_pending,
  output logic                      pc_load,
  output logic [PC_W-1:0]           pc_vector,
  output logic                      push_valid,
  output logic [PC_W-1:0]           push_addr,
  output logic [STACK_DEPTH*PC_W-1:0] stack_entries
);
  function automatic logic [PC_W-1:0] ret_addr(input logic [PC_W-1:0] pc);
    return pc + PC_W'(1);
  endfunction

  // Named internal events, visible to the bound checker.
  logic qual_evt;
  logic take_evt;

  irq_pulse_qual #(.LOW_TICKS(LOW_TICKS)) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (cyc_tick),
    .pin  (int_pin),
    .qual (qual_evt)
  );

  irq_take_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .qual      (qual_evt),
    .instr_done(instr_done),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .en_q      (int_en),
    .pend_q    (int_pending),
    .take      (take_evt)
  );

  assign pc_load    = take_evt;
  assign pc_vector  = PC_W'(VECTOR);
  assign push_valid = take_evt;
  assign push_addr  = ret_addr(pc_in);

  irq_ret_stack #(.W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (take_evt),
    .din    (push_addr),
    .entries(stack_entries)
  );
endmodule

// File: rtl/irq_recognizer_chk.sv
module irq_recognizer_chk #(
  parameter int PC_W  = 10,
  parameter int DEPTH = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  instr_done,
  input logic                  en_set,
  input logic                  en_clr,
  input logic                  int_en,
  input logic                  int_pending,
  input logic                  pc_load,
  input logic [PC_W-1:0]       pc_vector,
  input logic                  push_valid,
  input logic [PC_W-1:0]       push_addr,
  input logic [DEPTH*PC_W-1:0] stack_entries,
  input logic                  qual_evt
);
  a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_vector == PC_W'('h0FF)) && push_valid);

  a_r4_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> int_pending && instr_done);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    int_pending && !instr_done && !en_clr |=> int_pending);

  a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !int_en && !int_pending);

  a_r3_no_pend_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !int_pending);

  a_r3_latch_edge: assert property (@(posedge clk) disable iff (!rst_n)
    qual_evt && int_en && !pc_load && !en_clr |=> int_pending);

  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    en_set && !en_clr && !pc_load |=> int_en);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !int_en && !int_pending);

  a_r7_shift: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> (stack_entries[PC_W-1:0] == $past(push_addr)) &&
                   (stack_entries[2*PC_W-1:PC_W] == $past(stack_entries[PC_W-1:0])));

  a_r7_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid |=> $stable(stack_entries));
endmodule

bind irq_recognizer irq_recognizer_chk #(.PC_W(PC_W), .DEPTH(STACK_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .instr_done   (instr_done),
  .en_set       (en_set),
  .en_clr       (en_clr),
  .int_en       (int_en),
  .int_pending  (int_pending),
  .pc_load      (pc_load),
  .pc_vector    (pc_vector),
  .push_valid   (push_valid),
  .push_addr    (push_addr),
  .stack_entries(stack_entries),
  .qual_evt     (qual_evt)
);

// File: tb/irq_recognizer_tb.sv
module irq_recognizer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       int_pin = 1'b1;
  logic       instr_done = 1'b0;
  logic [9:0] pc_in = '0;
  logic       en_set = 1'b0;
  logic       en_clr = 1'b0;
  logic       int_en, int_pending, pc_load, push_valid;
  logic [9:0] pc_vector, push_addr;
  logic [29:0] stack_entries;

  int errors = 0;
  int checks = 0;
  int tick_cnt = 0;
  bit done_flag = 0;

  // Reference model state
  bit m_en = 0;
  bit m_pend = 0;
  bit m_armed = 0;
  int m_lows = 0;
  int m_stack[$] = '{0, 0, 0};

  irq_recognizer u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .int_pin(int_pin),
    .instr_done(instr_done), .pc_in(pc_in), .en_set(en_set), .en_clr(en_clr),
    .int_en(int_en), .int_pending(int_pending), .pc_load(pc_load),
    .pc_vector(pc_vector), .push_valid(push_valid), .push_addr(push_addr),
    .stack_entries(stack_entries)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: inputs already driven; compare, advance model, pass the edge.
  task automatic step();
    bit take, qual;
    int ret;
    #(CLK_PERIOD/4);
    take = m_pend && m_en && instr_done;
    ret  = (pc_in + 1) % 1024;
    check("R1/R3 int_en", int_en, m_en);
    check("R4 int_pending", int_pending, m_pend);
    check("R4 pc_load", pc_load, take);
    check("R6 push_valid", push_valid, take);
    if (take) begin
      check("R5 pc_vector", pc_vector, 'h0FF);
      check("R6 push_addr", push_addr, ret);
    end
    for (int i = 0; i < 3; i++)
      check("R7 stack entry", stack_entries[i*10 +: 10], m_stack[i]);
    qual = 0;
    if (cyc_tick) begin
      if (int_pin) begin m_armed = 1; m_lows = 0; end
      else if (m_armed) begin
        m_lows++;
        if (m_lows == 2) begin qual = 1; m_armed = 0; end
      end
    end
    if (take) begin m_stack.push_front(ret); void'(m_stack.pop_back()); end
    m_pend = m_en && !take && !en_clr && (m_pend || qual);
    if (take || en_clr) m_en = 0;
    else if (en_set) m_en = 1;
    @(negedge clk);
  endtask

  // Advance n clocks with an automatic instruction tick every TICK_DIV clocks.
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      cyc_tick = (tick_cnt % TICK_DIV) == 0;
      tick_cnt++;
      step();
    end
    cyc_tick = 0;
  endtask

  task automatic pulse_en(input bit s, input bit c);
    en_set = s; en_clr = c; run(1); en_set = 0; en_clr = 0;
  endtask

  task automatic finish_instr(input logic [9:0] pc);
    pc_in = pc; instr_done = 1; run(1); instr_done = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state, asserted inside reset
    check("R1 int_en", int_en, 0);
    check("R1 stack", stack_entries, 0);
    check("R1 pc_load", pc_load, 0);
    rst_n = 1;
    @(negedge clk);
    run(12);
    // R2 single-tick low glitch is rejected
    pulse_en(1, 0);
    run(8);
    int_pin = 0; run(TICK_DIV); int_pin = 1; run(12);
    check("R2 glitch ignored", int_pending, 0);
    // R2/R4/R10: long low pulse, done withheld
    int_pin = 0; run(40);
    check("R10 one event pending", int_pending, 1);
    finish_instr(10'h123);
    check("R8 enable cleared", int_en, 0);
    check("R7 newest entry", stack_entries[9:0], 10'h124);
    int_pin = 1; run(12);
    // R6 wrap of return address
    pulse_en(1, 0);
    int_pin = 0; run(12); int_pin = 1; run(4);
    finish_instr(10'h3FF);
    check("R6 wrapped push", stack_entries[9:0], 10'h000);
    // R3 edge while disabled is not remembered
    int_pin = 0; run(12); int_pin = 1; run(8);
    pulse_en(1, 0);
    run(4);
    check("R3 forgotten edge", int_pending, 0);
    finish_instr(10'h050);
    // R7 two more takes to overflow the stack
    for (int k = 0; k < 2; k++) begin
      int_pin = 0; run(12); int_pin = 1; run(4);
      finish_instr(10'h200 + 10'(k));
      pulse_en(1, 0);
    end
    check("R7 bottom lost", stack_entries[29:20], 10'h000);
    // R9 set and clear together: clear wins; clear drops pending
    int_pin = 0; run(12); int_pin = 1; run(4);
    check("R9 pending before clear", int_pending, 1);
    pulse_en(1, 1);
    check("R9 clear wins", int_en, 0);
    check("R9 pending dropped", int_pending, 0);
    // R8 take in the same cycle as en_set
    pulse_en(1, 0);
    int_pin = 0; run(12); int_pin = 1; run(4);
    en_set = 1; finish_instr(10'h2AA); en_set = 0;
    check("R8 take beats set", int_en, 0);
    run(8);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule